// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character into a framed bit stream on a single asynchronous output line. Each frame is a low start bit, five, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. Every bit lasts a fixed number of system clock cycles. That count is set by the `CLK_DIV` parameter and is measured by an internal divider.

A host requests a transfer with a four-phase handshake. It raises `send` and holds it high, and the block answers by raising `busy` for the whole frame. `busy` drops once the last stop bit has ended, and the host then lowers `send`. A second frame needs `send` to be seen low and then high again. The character and the frame-format inputs are captured when the frame starts, so the host may change them while a frame is on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `txd` is high and `busy` is low.
- R2: A frame starts on the clock edge that samples `send` high while the block is idle and armed. On that edge `txd` goes low for the start bit and `busy` goes high.
- R3: Data bits follow the start bit, least significant first. `fmt_len` sets the count: 2'b00 gives 5 bits, 2'b01 gives 7 bits, and 2'b10 or 2'b11 gives 8 bits.
- R4: When `fmt_par_en` is 1, one parity bit follows the last data bit. With `fmt_par_odd`=0 the parity bit equals the XOR of the data bits sent (even parity). With `fmt_par_odd`=1 it is the inverse of that XOR (odd parity). When `fmt_par_en` is 0, no parity bit is sent.
- R5: Stop bits are driven high. There is one stop bit when `fmt_stop2`=0 and two when `fmt_stop2`=1.
- R6: Every bit of the frame, including the start and stop bits, holds `txd` for exactly `CLK_DIV` clock cycles.
- R7: `busy` stays high from the start edge until the last stop bit ends. It falls exactly `CLK_DIV` times the frame's bit count cycles after it rose.
- R8: A frame starts only after `send` has been sampled low while idle, and then sampled high. Holding `send` high after `busy` falls, or holding it high through reset, starts no frame.
- R9: `data` and the format inputs are captured at the start edge. Changing them during a frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send | input | 1 | Host transfer request, held high until `busy` falls |
| data | input | 8 | Character to send; upper bits are unused for short formats |
| fmt_len | input | 2 | Data bit count select (00:5, 01:7, 1x:8) |
| fmt_par_en | input | 1 | Enable the parity bit |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| fmt_stop2 | input | 1 | 1 selects two stop bits, 0 selects one |
| busy | output | 1 | High while a frame is being sent |
| txd | output | 1 | Serial line output, idle high |

## Verification
The bench samples every bit just after it begins and just before it ends. A divider that is off by one cycle, or a frame that drops or repeats a bit, therefore shows up as a wrong line level at one of those points. It covers every data length, both parity senses and both stop counts, with patterns chosen so that wrong parity sense or MSB-first shifting gives a different bit. It keeps `send` high after `busy` falls, and also through reset. A design that started on the level of `send` instead of a fresh request would send a second frame there. It also changes the data and the format in the middle of a frame, which would corrupt the bits of a design that read its inputs live.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int CLK_DIV = 434
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send,
  input  logic [7:0] data,
  input  logic [1:0] fmt_len,
  input  logic       fmt_par_en,
  input  logic       fmt_par_odd,
  input  logic       fmt_stop2,
  output logic       busy,
  output logic       txd
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [7:0]    shreg;
  logic [2:0]    bit_idx;
  logic [2:0]    last_idx;
  logic          par_acc;
  logic          par_on;
  logic          two_stop;
  logic          stop_idx;
  logic          armed;

  wire tick  = busy && (cnt == CNT_LAST);
  wire start = !busy && armed && send;

  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (!busy && !send)
      armed <= 1'b1;
    else if (start)
      armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start || tick)
      cnt <= '0;
    else if (busy)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      busy     <= 1'b0;
      txd      <= 1'b1;
      shreg    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      par_acc  <= 1'b0;
      par_on   <= 1'b0;
      two_stop <= 1'b0;
      stop_idx <= 1'b0;
    end else if (start) begin
      phase    <= S_START;
      busy     <= 1'b1;
      txd      <= 1'b0;
      shreg    <= data;
      par_acc  <= fmt_par_odd;
      par_on   <= fmt_par_en;
      two_stop <= fmt_stop2;
      bit_idx  <= '0;
      case (fmt_len)
        2'b00:   last_idx <= 3'd4;
        2'b01:   last_idx <= 3'd6;
        default: last_idx <= 3'd7;
      endcase
    end else if (tick) begin
      case (phase)
        S_START: begin
          phase   <= S_DATA;
          txd     <= shreg[0];
          par_acc <= par_acc ^ shreg[0];
          shreg   <= {1'b0, shreg[7:1]};
          bit_idx <= '0;
        end
        S_DATA: begin
          if (bit_idx == last_idx) begin
            if (par_on) begin
              phase <= S_PAR;
              txd   <= par_acc;
            end else begin
              phase    <= S_STOP;
              txd      <= 1'b1;
              stop_idx <= 1'b0;
            end
          end else begin
            txd     <= shreg[0];
            par_acc <= par_acc ^ shreg[0];
            shreg   <= {1'b0, shreg[7:1]};
            bit_idx <= bit_idx + 1'b1;
          end
        end
        S_PAR: begin
          phase    <= S_STOP;
          txd      <= 1'b1;
          stop_idx <= 1'b0;
        end
        S_STOP: begin
          if (stop_idx == two_stop) begin
            phase <= S_IDLE;
            busy  <= 1'b0;
          end else begin
            stop_idx <= 1'b1;
          end
        end
        default: begin
          phase <= S_IDLE;
          busy  <= 1'b0;
          txd   <= 1'b1;
        end
      endcase
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STOP) |-> txd);

  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(txd));

  assert_busy_needs_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(send));

  assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy);
endmodule

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] fmt_len = 2'b10;
  logic fmt_par_en = 1'b0;
  logic fmt_par_odd = 1'b0;
  logic fmt_stop2 = 1'b0;
  logic busy, txd;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  uart_frame_tx #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .send(send), .data(data),
    .fmt_len(fmt_len), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
    .fmt_stop2(fmt_stop2), .busy(busy), .txd(txd)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                       input logic po, input logic s2, input logic mutate, input logic drop);
    logic exp_bits[12];
    int n;
    int nd;
    logic p;
    nd = (len == 2'b00) ? 5 : (len == 2'b01) ? 7 : 8;
    n = 0;
    exp_bits[n++] = 1'b0;
    p = po;
    for (int i = 0; i < nd; i++) begin
      exp_bits[n++] = d[i];
      p ^= d[i];
    end
    if (pe) exp_bits[n++] = p;
    exp_bits[n++] = 1'b1;
    if (s2) exp_bits[n++] = 1'b1;

    data = d; fmt_len = len; fmt_par_en = pe; fmt_par_odd = po; fmt_stop2 = s2;
    send = 1'b1;
    @(negedge clk);
    if (mutate) begin
      data = ~d; fmt_len = ~len; fmt_par_en = ~pe; fmt_par_odd = ~po; fmt_stop2 = ~s2;
    end
    for (int i = 0; i < n; i++) begin
      check((i == 0) ? "R2" : (i <= nd) ? (mutate ? "R9" : "R3") :
            (pe && i == nd + 1) ? "R4" : "R5", txd, exp_bits[i], "bit start");
      check("R7", busy, 1'b1, "busy in frame");
      repeat (DIV - 1) @(negedge clk);
      check("R6", txd, exp_bits[i], "bit end");
      @(negedge clk);
    end
    check("R7", busy, 1'b0, "busy after frame");
    check("R1", txd, 1'b1, "line after frame");
    if (drop) begin
      send = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    send = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", txd, 1'b1, "reset line");
    check("R1", busy, 1'b0, "reset busy");
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R8", busy, 1'b0, "send held through reset");
    end
    send = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_hold_send();
    frame(8'h3C, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R8", busy, 1'b0, "held send no restart");
      check("R8", txd, 1'b1, "held send line idle");
    end
    send = 1'b0;
    @(negedge clk);
    frame(8'hC3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    frame(8'hA5, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    frame(8'h4D, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    frame(8'h16, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    frame(8'hE1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    frame(8'h80, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    frame(8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    frame(8'hFF, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    frame(8'h6B, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    frame(8'h29, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    test_hold_send();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule